// File: doc/BRIEF.md
# Indirect Configuration and Port Access Bridge

This block sits on a host register bus. It turns programmed-I/O accesses into single read or write cycles on a simple downstream request/response bus. Software first loads a target address into a shared address register. A later access to one of two data windows then starts exactly one downstream cycle with that address. One window produces configuration cycles. The other produces I/O-port cycles. The offset of the data-window access selects the byte lanes, and the size field selects byte, halfword or word transfers.

A controller with three states paces every host access. In `ST_IDLE` an access is accepted. An access to the address register, or to an unmapped offset, goes to `ST_DONE` (transition *local*). A data-window access goes to `ST_WAIT` (transition *launch*). There the downstream request is held until the target acknowledges, and the host sees a stall. `ST_WAIT` goes to `ST_DONE` on acknowledge (transition *respond*). `ST_DONE` raises the one-cycle completion strobe and returns to `ST_IDLE` (transition *retire*). The host holds its request until it sees the strobe and drops it in that cycle.

Top module: `cpb_bridge`

## Requirements
- R1: After reset, `dn_req`, `host_done` and `host_stall` are low, and a read of the address register returns 0.
- R2: A write to the address register (word offset 0x064) starts no downstream cycle and completes one cycle after acceptance. A read of it returns the last value written, all 32 bits.
- R3: Each access to the configuration window (offsets 0x068..0x06B) issues exactly one downstream cycle with `dn_kind`=0. Its address is bus in bits 23:16, device/function in 15:8 and register offset in 7:2 of the address register, with bits 1:0 and 31:24 zero.
- R4: Each access to the port window (offsets 0x06C..0x06F) issues exactly one downstream cycle with `dn_kind`=1. Its address is the low 16 bits of the address register, zero-extended.
- R5: A byte access (`host_size`=00) uses the lane given by offset bits 1:0. Exactly that one `dn_be` bit is set. Write data from `host_wdata[7:0]` is placed on that lane with other lanes zero. Read data from that lane is returned in `host_rdata[7:0]` with the upper bits zero.
- R6: A halfword access (`host_size`=01) uses lanes 1:0 when offset bit 1 is 0 and lanes 3:2 when it is 1. Offset bit 0 is ignored. Data is right-justified in `host_wdata[15:0]` and `host_rdata[15:0]`.
- R7: A word access (`host_size`=10) sets all four byte enables, starting at lane 0, whatever the offset's low bits.
- R8: While a downstream cycle is outstanding, `dn_req` and its address, enables and direction stay stable and `host_stall` stays high. `host_done` rises one cycle after the `dn_ack` cycle and lasts one cycle. It never coincides with `dn_req`.
- R9: A downstream read that ends with `dn_err`=1 (no target) returns all ones on the selected lanes: 0xFF, 0xFFFF or 0xFFFFFFFF after justification.
- R10: An access to any other offset completes one cycle after acceptance, starts no downstream cycle, reads 0, and leaves the address register unchanged.
- R11: `dn_we` follows the direction of the host access, 1 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte offset of the access |
| host_size | input | 2 | 00 byte, 01 halfword, 10 word |
| host_wdata | input | 32 | Right-justified write data |
| host_stall | output | 1 | Access pending and not yet complete |
| host_done | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Right-justified read data, valid with `host_done` |
| dn_req | output | 1 | Downstream cycle request |
| dn_kind | output | 1 | 0 configuration, 1 I/O port |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream target address |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_ack | input | 1 | Downstream response strobe |
| dn_rdata | input | 32 | Downstream read data, all lanes |
| dn_err | input | 1 | No target responded |

## Verification
The assertions check on every cycle that an outstanding request and its fields stay stable until acknowledged, and that the completion strobe is a single cycle that never overlaps a request. They also check that configuration addresses keep bits 1:0 and 31:24 clear, that every request has a byte enable set, and that an address-register access never launches a cycle. Only the bench scenarios show the contents of the cycles. These are the exact address packing, lane and enable choice per size and offset, right-justified read data, all-ones on a missing target, readback, and the stall length for a given response delay.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_DONE = 2'd2} state_e;
    typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_ADDR = 2'd1, TGT_CFG = 2'd2, TGT_PORT = 2'd3} tgt_e;
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/cpb_lane_steer.sv
module cpb_lane_steer
    import cpb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [1:0]        size_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              rsp_err_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [LANE_W-1:0] base_c;
    logic [LANE_W:0]   nbytes_c;
    logic [LANE_W+2:0] shamt_c;
    logic [DATA_W-1:0] wmask_c;
    logic [DATA_W-1:0] raw_c;
    logic [DATA_W-1:0] shr_c;

    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                base_c   = lane_i;
                nbytes_c = (LANE_W+1)'(1);
            end
            SZ_HALF: begin
                base_c   = {lane_i[LANE_W-1:1], 1'b0};
                nbytes_c = (LANE_W+1)'(2);
            end
            default: begin
                base_c   = '0;
                nbytes_c = (LANE_W+1)'(LANES);
            end
        endcase
    end

    assign shamt_c = {base_c, 3'b000};
    assign raw_c   = rsp_err_i ? '1 : rsp_data_i;
    assign shr_c   = raw_c >> shamt_c;
    assign wdata_o = wmask_c << shamt_c;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic keep;
        assign keep = (LANE_W+1)'(i) < nbytes_c;
        assign be_o[i] = ({1'b0, base_c} <= (LANE_W+1)'(i)) &&
                         ((LANE_W+1)'(i) < ({1'b0, base_c} + nbytes_c));
        assign wmask_c[i*8 +: 8] = keep ? wdata_i[i*8 +: 8] : 8'h00;
        assign rdata_o[i*8 +: 8] = keep ? shr_c[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/cpb_ctrl_fsm.sv
module cpb_ctrl_fsm
    import cpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   host_req,
    input  tgt_e   tgt_i,
    input  logic   dn_ack,
    output state_e state_o,
    output logic   accept_o,
    output logic   dn_req_o,
    output logic   host_done_o,
    output logic   host_stall_o
);
    state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (host_req) nxt = (tgt_i == TGT_CFG || tgt_i == TGT_PORT) ? ST_WAIT : ST_DONE;
            ST_WAIT: if (dn_ack) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o      = st;
        accept_o     = (st == ST_IDLE) && host_req;
        dn_req_o     = (st == ST_WAIT);
        host_done_o  = (st == ST_DONE);
        host_stall_o = host_req && (st != ST_DONE);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done_o |=> !host_done_o);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && !dn_ack) |=> dn_req_o);
    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> !host_done_o);
endmodule

// File: rtl/cpb_bridge.sv
module cpb_bridge
    import cpb_pkg::*;
#(
    parameter int HOST_AW = 12,
    parameter int DATA_W = 32,
    parameter int DN_AW = 32,
    parameter int unsigned ADDR_OFS = 'h064,
    parameter int unsigned CFG_OFS = 'h068,
    parameter int unsigned PORT_OFS = 'h06C,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [1:0]         host_size,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_stall,
    output logic               host_done,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               dn_req,
    output logic               dn_kind,
    output logic               dn_we,
    output logic [DN_AW-1:0]   dn_addr,
    output logic [LANES-1:0]   dn_be,
    output logic [DATA_W-1:0]  dn_wdata,
    input  logic               dn_ack,
    input  logic [DATA_W-1:0]  dn_rdata,
    input  logic               dn_err
);
    localparam int WA_W = HOST_AW - LANE_W;

    tgt_e              tgt_c, tgt_q;
    state_e            st;
    logic              accept;
    logic              we_q;
    logic [1:0]        size_q;
    logic [LANE_W-1:0] lane_q;
    logic [DATA_W-1:0] wdata_q, addr_q, rdata_q, steer_rd;
    logic [WA_W-1:0]   word_a;

    assign word_a = host_addr[HOST_AW-1:LANE_W];

    always_comb begin
        if (word_a == WA_W'(ADDR_OFS >> LANE_W))      tgt_c = TGT_ADDR;
        else if (word_a == WA_W'(CFG_OFS >> LANE_W))  tgt_c = TGT_CFG;
        else if (word_a == WA_W'(PORT_OFS >> LANE_W)) tgt_c = TGT_PORT;
        else                                          tgt_c = TGT_NONE;
    end

    cpb_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .tgt_i        (tgt_c),
        .dn_ack       (dn_ack),
        .state_o      (st),
        .accept_o     (accept),
        .dn_req_o     (dn_req),
        .host_done_o  (host_done),
        .host_stall_o (host_stall)
    );

    cpb_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .size_i     (size_q),
        .lane_i     (lane_q),
        .wdata_i    (wdata_q),
        .rsp_data_i (dn_rdata),
        .rsp_err_i  (dn_err),
        .be_o       (dn_be),
        .wdata_o    (dn_wdata),
        .rdata_o    (steer_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= TGT_NONE;
            we_q    <= 1'b0;
            size_q  <= '0;
            lane_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            tgt_q   <= tgt_c;
            we_q    <= host_we;
            size_q  <= host_size;
            lane_q  <= host_addr[LANE_W-1:0];
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else if (accept && host_we && tgt_c == TGT_ADDR) addr_q <= host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= (!host_we && tgt_c == TGT_ADDR) ? addr_q : '0;
        end else if (st == ST_WAIT && dn_ack) begin
            rdata_q <= we_q ? '0 : steer_rd;
        end
    end

    assign host_rdata = rdata_q;
    assign dn_we      = we_q;
    assign dn_kind    = (tgt_q == TGT_PORT);
    assign dn_addr    = dn_kind ? DN_AW'(addr_q[15:0]) : DN_AW'({addr_q[23:2], 2'b00});

    // R8
    dn_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> ($stable(dn_addr) && $stable(dn_be) && $stable(dn_we) && $stable(dn_kind)));
    // R2
    addr_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && host_req && tgt_c == TGT_ADDR) |=> !dn_req);
    // R3
    cfg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_kind) |-> (dn_addr[1:0] == 2'b00 && dn_addr[DN_AW-1:24] == '0));
    // R5
    be_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_be != '0));
endmodule

// File: tb/cpb_bridge_tb_top.sv
`timescale 1ns/1ps
module cpb_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_stall, host_done;
    logic [31:0] host_rdata;
    logic        dn_req, dn_kind, dn_we;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        dn_ack = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        logic        kind;
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rsp;
        logic        err;
        int          dly;
    } dn_item_t;
    dn_item_t exp_q[$];

    always #2.5 clk = ~clk;

    cpb_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_stall(host_stall), .host_done(host_done), .host_rdata(host_rdata),
        .dn_req(dn_req), .dn_kind(dn_kind), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_err(dn_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected downstream cycles and answers them
    initial begin
        forever begin
            @(negedge clk);
            if (dn_req && !dn_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R10 unexpected downstream cycle", dn_addr, 32'h0);
                    dn_ack = 1'b1; dn_err = 1'b1;
                    @(negedge clk);
                    dn_ack = 1'b0; dn_err = 1'b0;
                end else begin
                    dn_item_t it;
                    it = exp_q.pop_front();
                    chk(dn_kind == it.kind, "R3/R4 kind", {31'b0, dn_kind}, {31'b0, it.kind});
                    chk(dn_we == it.we, "R11 direction", {31'b0, dn_we}, {31'b0, it.we});
                    chk(dn_addr == it.addr, "R3/R4 address", dn_addr, it.addr);
                    chk(dn_be == it.be, "R5/R6/R7 byte enables", {28'b0, dn_be}, {28'b0, it.be});
                    if (it.we) chk(dn_wdata == it.wdata, "R5/R6/R7 write lanes", dn_wdata, it.wdata);
                    for (int k = 0; k < it.dly; k++) begin
                        chk(host_stall && dn_req, "R8 stall while outstanding", {31'b0, host_stall}, 32'h1);
                        @(negedge clk);
                    end
                    dn_ack = 1'b1; dn_rdata = it.rsp; dn_err = it.err;
                    @(negedge clk);
                    dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = '0;
                end
            end
        end
    end

    task automatic push(input logic kind, input logic we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [31:0] rsp, input logic err, input int dly);
        dn_item_t it;
        it.kind = kind; it.we = we; it.addr = addr; it.be = be;
        it.wdata = wd; it.rsp = rsp; it.err = err; it.dly = dly;
        exp_q.push_back(it);
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd,
                          input bit chk_rd, input logic [31:0] exp_rd, input int exp_lat, input string tag);
        int lat;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_done && lat < 100);
        chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
        if (chk_rd) chk(host_rdata == exp_rd, {tag, " read data"}, host_rdata, exp_rd);
        chk(exp_q.size() == 0, {tag, " exactly one cycle"}, 32'(exp_q.size()), 32'h0);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL R8 watchdog actual=hang expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!dn_req && !host_done && !host_stall, "R1 idle outputs", {29'b0, dn_req, host_done, host_stall}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 12'h064, 2'b10, 32'h0, 1'b1, 32'h0, 1, "R1 address register after reset");

        // R2 write, no downstream cycle, readback
        access(1'b1, 12'h064, 2'b10, 32'hFFAB3C47, 1'b0, 32'h0, 1, "R2 address write");
        access(1'b0, 12'h064, 2'b10, 32'h0, 1'b1, 32'hFFAB3C47, 1, "R2 address readback");

        // R3 R7 R8: word config read, delay 2
        push(1'b0, 1'b0, 32'h00AB3C44, 4'hF, 32'h0, 32'hDEADBEEF, 1'b0, 2);
        access(1'b0, 12'h068, 2'b10, 32'h0, 1'b1, 32'hDEADBEEF, 4, "R3 R7 config word read");
        // R7 word ignores offset low bits
        push(1'b0, 1'b0, 32'h00AB3C44, 4'hF, 32'h0, 32'h01020304, 1'b0, 0);
        access(1'b0, 12'h06B, 2'b10, 32'h0, 1'b1, 32'h01020304, 2, "R7 word at odd offset");
        // R5 byte write lane 2
        push(1'b0, 1'b1, 32'h00AB3C44, 4'b0100, 32'h005A0000, 32'h0, 1'b0, 1);
        access(1'b1, 12'h06A, 2'b00, 32'hFFFFFF5A, 1'b0, 32'h0, 3, "R5 config byte write");
        // R5 byte read lane 3
        push(1'b0, 1'b0, 32'h00AB3C44, 4'b1000, 32'h0, 32'h11223344, 1'b0, 0);
        access(1'b0, 12'h06B, 2'b00, 32'h0, 1'b1, 32'h00000011, 2, "R5 config byte read");
        // R6 halfword read upper, bit 0 ignored
        push(1'b0, 1'b0, 32'h00AB3C44, 4'b1100, 32'h0, 32'hCAFE0102, 1'b0, 0);
        access(1'b0, 12'h06B, 2'b01, 32'h0, 1'b1, 32'h0000CAFE, 2, "R6 config half read");
        // R6 halfword write lower
        push(1'b0, 1'b1, 32'h00AB3C44, 4'b0011, 32'h00001234, 32'h0, 1'b0, 0);
        access(1'b1, 12'h069, 2'b01, 32'hABCD1234, 1'b0, 32'h0, 2, "R6 config half write");

        // R4: port address
        access(1'b1, 12'h064, 2'b10, 32'h77AA03F8, 1'b0, 32'h0, 1, "R2 address write port");
        // R4 R9 byte read with no target
        push(1'b1, 1'b0, 32'h000003F8, 4'b0010, 32'h0, 32'h12345678, 1'b1, 1);
        access(1'b0, 12'h06D, 2'b00, 32'h0, 1'b1, 32'h000000FF, 3, "R4 R9 port byte read no target");
        // R4 R7 R11 word write
        push(1'b1, 1'b1, 32'h000003F8, 4'hF, 32'h89ABCDEF, 32'h0, 1'b0, 0);
        access(1'b1, 12'h06C, 2'b10, 32'h89ABCDEF, 1'b0, 32'h0, 2, "R4 R11 port word write");
        // R9 half read no target
        push(1'b1, 1'b0, 32'h000003F8, 4'b1100, 32'h0, 32'h0, 1'b1, 0);
        access(1'b0, 12'h06E, 2'b01, 32'h0, 1'b1, 32'h0000FFFF, 2, "R9 port half read no target");
        // R9 word read no target
        push(1'b1, 1'b0, 32'h000003F8, 4'hF, 32'h0, 32'h0, 1'b1, 0);
        access(1'b0, 12'h06C, 2'b10, 32'h0, 1'b1, 32'hFFFFFFFF, 2, "R9 port word read no target");

        // R10 unmapped offsets
        access(1'b1, 12'h070, 2'b10, 32'h12345678, 1'b0, 32'h0, 1, "R10 unmapped write");
        access(1'b1, 12'h060, 2'b10, 32'h87654321, 1'b0, 32'h0, 1, "R10 unmapped write below");
        access(1'b0, 12'h070, 2'b10, 32'h0, 1'b1, 32'h0, 1, "R10 unmapped read");
        access(1'b0, 12'h064, 2'b10, 32'h0, 1'b1, 32'h77AA03F8, 1, "R10 address register untouched");

        // R8 long stall on config write
        access(1'b1, 12'h064, 2'b10, 32'h00010800, 1'b0, 32'h0, 1, "R2 address write config");
        push(1'b0, 1'b1, 32'h00010800, 4'hF, 32'hA5A55A5A, 32'h0, 1'b0, 6);
        access(1'b1, 12'h068, 2'b10, 32'hA5A55A5A, 1'b0, 32'h0, 8, "R8 config write long stall");

        repeat (3) @(negedge clk);
        chk(!dn_req && !host_done, "R8 quiet after completion", {30'b0, dn_req, host_done}, 32'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule